// File: doc/BRIEF.md
# Generalized Triangle Strip Decoder

This block turns a packed per-meshlet bit stream into a stream of triangles. Each triangle comes out as three 8-bit local vertex indices. A meshlet opens with a header and one fully spelled-out triangle. Every later triangle reuses one edge of the triangle before it and adds one new vertex. A one-bit side flag picks the reused edge. The new vertex index is either implied as the last new index plus one, or read explicitly from the stream.

Input words arrive on a ready/valid port and go into an internal bit buffer, which is read least significant bit first. Triangles leave on a ready/valid port at a rate of at most one per clock, and a marker flags the last triangle of each meshlet. A sticky flag records an implied index that ran past 255.

Top module: `tstrip_decoder`

## Requirements
- R1: While the synchronous reset is high and on the cycle after it falls, `tri_valid` and `wrap_err` are 0 and `in_ready` is 1.
- R2: A meshlet starts with an 8-bit field holding the triangle count minus one. Three 8-bit explicit indices follow, in the order a, b, c, and together they form the first triangle.
- R3: Each later triangle starts with a side bit, and the previous triangle is (a,b,c) with c the newest vertex. A side bit of 0 emits (a,c,n), and a side bit of 1 emits (c,b,n). The emitted triple then becomes the previous triangle.
- R4: The second bit of each later triangle is the increment bit. When it is 1, n equals the previous triangle's c plus one (modulo 256), and the triangle uses only 2 stream bits.
- R5: When the increment bit is 0, the next 8 bits hold n explicitly, so the triangle uses 10 bits.
- R6: An implied index that steps from 255 to 0 sets `wrap_err`. The flag stays at 1 until reset.
- R7: Triangle counts from 1 to 256 are decoded. `tri_last` is 1 on exactly the final triangle of each meshlet.
- R8: While `tri_valid` is 1 and `tri_ready` is 0, the outputs stay unchanged on the next clock and `in_ready` is 0.
- R9: Fields are taken from each 32-bit word starting at bit 0. Meshlets follow one another with no padding, and a field may straddle a word boundary.
- R10: Raising the reset in the middle of a meshlet discards all buffered bits and strip state. The next stream after reset decodes from a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Packed stream word |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Word accepted this cycle when valid |
| tri_a | output | 8 | First index of triangle |
| tri_b | output | 8 | Second index of triangle |
| tri_c | output | 8 | Third (newest) index of triangle |
| tri_last | output | 1 | Final triangle of meshlet |
| tri_valid | output | 1 | Triangle present |
| tri_ready | input | 1 | Consumer takes triangle |
| wrap_err | output | 1 | Sticky implied-index overflow |

## Verification
The bench targets several corner cases:
- Side bits are mixed so that a design with swapped edge selection emits wrong first or second indices.
- Implied and explicit indices are interleaved, so that consuming 10 bits after a set increment bit (or 2 bits after a clear one) misaligns every later field.
- A strip climbs through 254 and 255 to show the wrap to 0 and the sticky flag.
- Meshlets of 1 and 256 triangles are run back to back, so an off-by-one in the count shows up as a missing or extra last marker.
- Random stalls on both ports catch outputs that change or words that are lost while the consumer is stalled.
- A reset in mid-meshlet catches leftover buffered bits.

// File: rtl/tstrip_decoder.sv
module tstrip_decoder #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [IDX_W-1:0]  tri_a,
  output logic [IDX_W-1:0]  tri_b,
  output logic [IDX_W-1:0]  tri_c,
  output logic              tri_last,
  output logic              tri_valid,
  input  logic              tri_ready,
  output logic              wrap_err
);
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam logic [CNT_W-1:0] HDR_BITS   = CNT_W'(IDX_W);
  localparam logic [CNT_W-1:0] FIRST_BITS = CNT_W'(3 * IDX_W);
  localparam logic [CNT_W-1:0] INC_BITS   = CNT_W'(2);
  localparam logic [CNT_W-1:0] EXP_BITS   = CNT_W'(IDX_W + 2);
  localparam logic [CNT_W-1:0] ROOM       = CNT_W'(WORD_W);

  typedef enum logic [1:0] {S_HDR, S_FIRST, S_STEP} st_t;

  st_t              st;
  logic [BUF_W-1:0] bits;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rem;

  logic             slot_free, side, inc, fire, emit, accept;
  logic [CNT_W-1:0] need, take, kept;
  logic [IDX_W-1:0] n_idx;

  assign slot_free = !tri_valid || tri_ready;
  assign side      = bits[0];
  assign inc       = bits[1];
  assign n_idx     = inc ? tri_c + 1'b1 : bits[IDX_W+1:2];

  always_comb begin
    case (st)
      S_HDR:   need = HDR_BITS;
      S_FIRST: need = FIRST_BITS;
      default: need = (cnt >= INC_BITS && !inc) ? EXP_BITS : INC_BITS;
    endcase
  end

  assign fire     = (cnt >= need) && (st == S_HDR || slot_free);
  assign emit     = fire && st != S_HDR;
  assign take     = fire ? need : '0;
  assign kept     = cnt - take;
  assign in_ready = (cnt <= ROOM) && slot_free;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HDR;
      bits      <= '0;
      cnt       <= '0;
      rem       <= '0;
      tri_a     <= '0;
      tri_b     <= '0;
      tri_c     <= '0;
      tri_last  <= 1'b0;
      tri_valid <= 1'b0;
      wrap_err  <= 1'b0;
    end else begin
      bits <= (bits >> take) |
              (accept ? ({{(BUF_W-WORD_W){1'b0}}, in_data} << kept) : '0);
      cnt  <= kept + (accept ? ROOM : '0);
      if (emit) tri_valid <= 1'b1;
      else if (tri_ready) tri_valid <= 1'b0;
      if (fire) begin
        case (st)
          S_HDR: begin
            rem <= bits[IDX_W-1:0];
            st  <= S_FIRST;
          end
          S_FIRST: begin
            tri_a    <= bits[IDX_W-1:0];
            tri_b    <= bits[2*IDX_W-1:IDX_W];
            tri_c    <= bits[3*IDX_W-1:2*IDX_W];
            tri_last <= (rem == '0);
            st       <= (rem == '0) ? S_HDR : S_STEP;
          end
          default: begin
            tri_a    <= side ? tri_c : tri_a;
            tri_b    <= side ? tri_b : tri_c;
            tri_c    <= n_idx;
            tri_last <= (rem == IDX_W'(1));
            rem      <= rem - 1'b1;
            st       <= (rem == IDX_W'(1)) ? S_HDR : S_STEP;
            if (inc && (&tri_c)) wrap_err <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tstrip_decoder_chk.sv
module tstrip_decoder_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic [IDX_W-1:0] tri_a,
  input logic [IDX_W-1:0] tri_b,
  input logic [IDX_W-1:0] tri_c,
  input logic             tri_last,
  input logic             tri_valid,
  input logic             tri_ready,
  input logic             wrap_err
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!tri_valid && !wrap_err));

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (tri_valid && !tri_ready) |=>
      (tri_valid && $stable(tri_a) && $stable(tri_b) && $stable(tri_c) && $stable(tri_last)));

  p_no_accept_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (tri_valid && !tri_ready) |-> !in_ready);

  p_edge_shared_r3: assert property (@(posedge clk) disable iff (rst)
    (tri_valid && tri_ready && !tri_last) |=>
      (!tri_valid ||
       (tri_a == $past(tri_a) && tri_b == $past(tri_c)) ||
       (tri_a == $past(tri_c) && tri_b == $past(tri_b))));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    wrap_err |=> wrap_err);
endmodule

bind tstrip_decoder tstrip_decoder_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_tstrip_decoder.sv
module tb_tstrip_decoder;
  logic        clk = 0, rst = 1;
  logic [31:0] in_data = 0;
  logic        in_valid = 0, in_ready;
  logic [7:0]  tri_a, tri_b, tri_c;
  logic        tri_last, tri_valid, tri_ready = 0, wrap_err;

  tstrip_decoder dut (.*);

  always #5 clk = ~clk;

  typedef struct { int a, b, c; bit last, wrap; string tag; } tri_t;
  bit          bitq[$];
  logic [31:0] wq[$];
  tri_t        expq[$];
  int tests = 0, fails = 0, cycles = 0, rx = 0, sent = 0;
  int ma, mb, mc, mleft;
  bit exp_err, prev_stall;
  logic [31:0] rnd = 32'h1234_5678;
  logic [7:0] ha, hb, hc; logic hl;

  task automatic check(bit ok, string tag, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int nxt();
    rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
    return int'(rnd & 32'h7fff_ffff);
  endfunction

  task automatic put(int v, int n);
    for (int i = 0; i < n; i++) bitq.push_back(bit'((v >> i) & 1));
  endtask

  task automatic push_tri(string tag, bit wrap);
    tri_t t;
    t.a = ma; t.b = mb; t.c = mc; t.last = (mleft == 1); t.wrap = wrap; t.tag = tag;
    expq.push_back(t); mleft--; sent++;
  endtask

  task automatic begin_mesh(int count, int a, int b, int c);
    put(count - 1, 8); put(a, 8); put(b, 8); put(c, 8);
    ma = a; mb = b; mc = c; mleft = count;
    push_tri("R2", 0);
  endtask

  task automatic step(bit lr, bit inc, int idx);
    int n; bit w;
    n = inc ? (mc + 1) % 256 : idx;
    w = inc && mc == 255;
    put(lr, 1); put(inc, 1); if (!inc) put(idx, 8);
    if (lr) begin ma = mc; end else begin mb = mc; end
    mc = n;
    push_tri(w ? "R6" : (inc ? "R3/R4" : "R3/R5"), w);
  endtask

  task automatic rand_mesh(int count);
    begin_mesh(count, nxt() % 256, nxt() % 256, nxt() % 256);
    for (int k = 1; k < count; k++) step(bit'(nxt() & 1), bit'((nxt() >> 3) & 1), nxt() % 256);
  endtask

  task automatic flush();
    while (bitq.size() > 0) begin
      logic [31:0] w = 0;
      for (int i = 0; i < 32; i++) if (bitq.size() > 0) w[i] = bitq.pop_front();
      wq.push_back(w);
    end
  endtask

  task automatic observe();
    if (prev_stall)
      check(tri_valid && tri_a == ha && tri_b == hb && tri_c == hc && tri_last == hl,
            "R8 hold", {tri_a, tri_b, tri_c}, {ha, hb, hc});
    if (tri_valid) begin
      if (expq.size() == 0) check(0, "R7 unexpected triangle", {tri_a, tri_b, tri_c}, 0);
      else begin
        if (expq[0].wrap) exp_err = 1;
        check(tri_a == expq[0].a && tri_b == expq[0].b && tri_c == expq[0].c, expq[0].tag,
              {tri_a, tri_b, tri_c}, (expq[0].a << 16) | (expq[0].b << 8) | expq[0].c);
        check(tri_last == expq[0].last, "R7 last", tri_last, expq[0].last);
      end
    end
    check(wrap_err == exp_err, "R6 err flag", wrap_err, exp_err);
  endtask

  task automatic run(int mode, int maxc);
    int c = 0;
    prev_stall = 0;
    while ((wq.size() > 0 || expq.size() > 0) && c < maxc) begin
      @(negedge clk); c++;
      observe();
      tri_ready = mode == 0 ? 1'b1 : bit'((nxt() % 3) != 0);
      in_valid  = wq.size() > 0 && (mode == 0 || bit'((nxt() % 4) != 0));
      in_data   = wq.size() > 0 ? wq[0] : 32'h0;
      #1;
      prev_stall = tri_valid && !tri_ready;
      ha = tri_a; hb = tri_b; hc = tri_c; hl = tri_last;
      if (prev_stall) check(!in_ready, "R8 in_ready low", in_ready, 0);
      if (tri_valid && tri_ready) begin void'(expq.pop_front()); rx++; end
      if (in_valid && in_ready) void'(wq.pop_front());
    end
    in_valid = 0;
    if (c < maxc) repeat (4) begin
      @(negedge clk); observe(); tri_ready = 1; prev_stall = 0;
    end
  endtask

  task automatic do_reset(string tag);
    rst = 1; in_valid = 0; tri_ready = 0;
    wq.delete(); expq.delete(); bitq.delete(); exp_err = 0; rx = 0; sent = 0;
    repeat (2) @(negedge clk);
    check(!tri_valid && !wrap_err && in_ready, tag, {tri_valid, wrap_err, in_ready}, 1);
    rst = 0;
    @(negedge clk);
    check(!tri_valid && !wrap_err && in_ready, tag, {tri_valid, wrap_err, in_ready}, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");

    begin_mesh(1, 5, 6, 7);
    begin_mesh(4, 1, 2, 3); step(0, 1, 0); step(1, 0, 200); step(0, 0, 9);
    flush(); run(0, 400);

    do_reset("R1 reset");
    begin_mesh(5, 10, 20, 254); step(0, 1, 0); step(1, 1, 0); step(0, 0, 7); step(1, 1, 0);
    flush(); run(0, 400);
    check(wrap_err == 1, "R6 sticky after stream", wrap_err, 1);

    do_reset("R1 reset");
    for (int m = 0; m < 8; m++) rand_mesh(2 + (nxt() % 40));
    flush(); run(1, 20000);
    check(rx == sent, "R9 contiguous meshlets count", rx, sent);

    do_reset("R1 reset");
    rand_mesh(256); rand_mesh(1); rand_mesh(256);
    flush(); run(1, 40000);
    check(rx == sent, "R7 full meshlets count", rx, sent);

    do_reset("R1 reset");
    rand_mesh(60); flush(); run(0, 12);
    do_reset("R10 reset mid-meshlet");
    begin_mesh(3, 40, 41, 42); step(1, 0, 77); step(0, 1, 0);
    flush(); run(0, 400);
    check(rx == sent, "R10 decode after reset", rx, sent);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule